// File: doc/BRIEF.md
# Fully Associative Line Store with Rotating Victim Pointer

This block is the lookup and storage core of a small fully associative cache. It keeps 64 lines of 32 bytes. Each line has a valid flag and a tag made from the upper 27 bits of a 32-bit byte address. There is no set index, so any line can sit in any slot. On every lookup, all stored tags are compared with the address at once. One clock later the block returns a hit flag, the slot number both as a binary value and as a one-hot vector, the line contents, and an error flag that shows when more than one slot matched.

A single rotating pointer chooses the slot to replace, as a cheap approximation of least-recently-used. The pointer moves forward by one only when the slot it names is accessed, either by a lookup hit or by a fill. It stays put on any other access. The fill port writes a new tag and line into the slot the pointer names. The pointer is visible at the ports, so the miss handler outside the block knows which slot is about to be overwritten. Write policy and the path to memory are handled elsewhere.

Top module: `assoc_line_cache`

## Requirements
- R1: Synchronous active-high reset marks every slot empty, sets the victim pointer to slot 0 and clears `lk_done`; lookups after reset miss.
- R2: A lookup presented with `lk_valid` high at a rising edge produces its result at that edge, with `lk_done` high for exactly one cycle; `lk_done` is low in cycles that follow no request.
- R3: The tag is address bits 31:5 and bits 4:0 (byte select) take no part in the compare; a lookup hits when a valid slot holds a tag equal to the address tag.
- R4: On a hit, `lk_hit` is 1, `lk_way` gives the slot number, `lk_onehot` has only bit `lk_way` set and `lk_data` holds that slot's 256-bit line; on a miss, `lk_hit` is 0 and `lk_way`, `lk_onehot`, `lk_data` and `lk_multi` are all zero.
- R5: When two or more valid slots match, `lk_multi` is 1 and the result (way, one-hot, data) is that of the lowest-numbered matching slot.
- R6: A lookup hit on the slot named by the victim pointer advances the pointer by one; a hit on any other slot, a miss, or an idle cycle leaves it unchanged.
- R7: A fill (`fill_valid` high at an edge) writes the tag of `fill_addr`, a set valid flag and `fill_data` into the slot named by the pointer, replacing what was there, and advances the pointer by one.
- R8: The pointer wraps from slot 63 to slot 0.
- R9: When a fill and a lookup occur in the same cycle, the lookup sees the contents from before the fill, and the pointer advances exactly once.
- R10: `victim_way` always shows the current pointer, which is the slot the next fill will write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Lookup byte address |
| lk_done | output | 1 | Lookup result valid (one cycle after request) |
| lk_hit | output | 1 | Lookup hit |
| lk_way | output | 6 | Binary slot number of the hit |
| lk_onehot | output | 64 | One-hot slot vector of the hit |
| lk_data | output | 256 | Line contents of the hit slot |
| lk_multi | output | 1 | More than one valid slot matched |
| fill_valid | input | 1 | Write a new line into the victim slot |
| fill_addr | input | 32 | Byte address whose tag is stored |
| fill_data | input | 256 | Line contents to store |
| victim_way | output | 6 | Current replacement pointer |

## Verification
A corrupted pointer shows up at `victim_way` on the very next cycle. It also shows up one lookup later, because a fill lands in a slot other than the one the model expects, and the old tag then still hits. A stale or lost valid flag or tag shows up on the next lookup of that block as a wrong hit flag, slot number or line. A fault in the compare or in the priority logic shows up as a wrong `lk_way` or `lk_multi` as soon as two slots hold the same tag. The scoreboard keeps its own copy of every slot and of the pointer, and compares each result in the cycle after its request.

// File: rtl/assoc_pkg.sv
package assoc_pkg;
  // Default geometry of the line store
  localparam int A_ADDR_W     = 32;
  localparam int A_LINE_BYTES = 32;
  localparam int A_ENTRIES    = 64;
endpackage

// File: rtl/assoc_tag_cam.sv
// Valid flags and tags for every slot, with one comparator per slot.
module assoc_tag_cam #(
  parameter int ENTRIES = 64,
  parameter int TAG_W   = 27,
  parameter int WAY_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [WAY_W-1:0]   wr_idx,
  input  logic [TAG_W-1:0]   wr_tag,
  input  logic [TAG_W-1:0]   cmp_tag,
  output logic [ENTRIES-1:0] match
);
  logic [ENTRIES-1:0] vld_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        vld_q[g] <= 1'b0;
      end else if (wr_en && wr_idx == WAY_W'(g)) begin
        vld_q[g] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (wr_en && wr_idx == WAY_W'(g)) begin
        tag_q[g] <= wr_tag;
      end
    end

    assign match[g] = vld_q[g] && (tag_q[g] == cmp_tag);
  end
endmodule

// File: rtl/assoc_first_match.sv
// Picks the lowest-numbered match and flags multiple matches.
module assoc_first_match #(
  parameter int ENTRIES = 64,
  parameter int WAY_W   = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] match,
  output logic               any,
  output logic [WAY_W-1:0]   way,
  output logic               multi
);
  always_comb begin
    way = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) way = WAY_W'(i);
    end
  end

  assign any   = |match;
  assign multi = |(match & (match - 1'b1));
endmodule

// File: rtl/assoc_victim_ptr.sv
// Rotating replacement pointer; moves only when its slot is touched.
module assoc_victim_ptr #(
  parameter int ENTRIES = 64,
  parameter int WAY_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  output logic [WAY_W-1:0] ptr
);
  localparam logic [WAY_W-1:0] LAST = WAY_W'(ENTRIES - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (step) begin
      ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end
  end
endmodule

// File: rtl/assoc_line_ram.sv
// Simple dual-port line storage with a registered read (block RAM style).
module assoc_line_ram #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/assoc_line_cache.sv
// Fully associative line store: parallel tag compare, registered result,
// fill into the slot named by a rotating victim pointer.
module assoc_line_cache
  import assoc_pkg::*;
#(
  parameter int ADDR_W     = A_ADDR_W,
  parameter int LINE_BYTES = A_LINE_BYTES,
  parameter int ENTRIES    = A_ENTRIES
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         lk_valid,
  input  logic [ADDR_W-1:0]            lk_addr,
  output logic                         lk_done,
  output logic                         lk_hit,
  output logic [$clog2(ENTRIES)-1:0]   lk_way,
  output logic [ENTRIES-1:0]           lk_onehot,
  output logic [LINE_BYTES*8-1:0]      lk_data,
  output logic                         lk_multi,
  input  logic                         fill_valid,
  input  logic [ADDR_W-1:0]            fill_addr,
  input  logic [LINE_BYTES*8-1:0]      fill_data,
  output logic [$clog2(ENTRIES)-1:0]   victim_way
);
  localparam int OFS_W  = $clog2(LINE_BYTES);
  localparam int TAG_W  = ADDR_W - OFS_W;
  localparam int LINE_W = LINE_BYTES * 8;
  localparam int WAY_W  = $clog2(ENTRIES);

  logic [TAG_W-1:0]   lk_tag, fill_tag;
  logic [ENTRIES-1:0] match;
  logic               any_hit, many_hit;
  logic [WAY_W-1:0]   first_way;
  logic [WAY_W-1:0]   ptr;
  logic               ptr_step;
  logic [LINE_W-1:0]  ram_q;
  logic               unused_ofs;

  assign lk_tag     = lk_addr[ADDR_W-1:OFS_W];
  assign fill_tag   = fill_addr[ADDR_W-1:OFS_W];
  assign unused_ofs = ^{lk_addr[OFS_W-1:0], fill_addr[OFS_W-1:0]};

  assoc_tag_cam #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_cam (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (fill_valid),
    .wr_idx  (ptr),
    .wr_tag  (fill_tag),
    .cmp_tag (lk_tag),
    .match   (match)
  );

  assoc_first_match #(.ENTRIES(ENTRIES), .WAY_W(WAY_W)) u_pick (
    .match (match),
    .any   (any_hit),
    .way   (first_way),
    .multi (many_hit)
  );

  // A fill touches the pointed slot; so does a lookup hit on it.
  assign ptr_step = fill_valid | (lk_valid & any_hit & (first_way == ptr));

  assoc_victim_ptr #(.ENTRIES(ENTRIES), .WAY_W(WAY_W)) u_ptr (
    .clk  (clk),
    .rst  (rst),
    .step (ptr_step),
    .ptr  (ptr)
  );

  assoc_line_ram #(.DEPTH(ENTRIES), .WIDTH(LINE_W), .AW(WAY_W)) u_ram (
    .clk   (clk),
    .we    (fill_valid),
    .waddr (ptr),
    .wdata (fill_data),
    .re    (lk_valid),
    .raddr (first_way),
    .rdata (ram_q)
  );

  logic               done_q, hit_q, multi_q;
  logic [WAY_W-1:0]   way_q;
  logic [ENTRIES-1:0] onehot_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q   <= 1'b0;
      hit_q    <= 1'b0;
      multi_q  <= 1'b0;
      way_q    <= '0;
      onehot_q <= '0;
    end else begin
      done_q <= lk_valid;
      if (lk_valid) begin
        hit_q    <= any_hit;
        multi_q  <= many_hit;
        way_q    <= any_hit ? first_way : '0;
        onehot_q <= '0;
        onehot_q[first_way] <= any_hit;
      end
    end
  end

  assign lk_done    = done_q;
  assign lk_hit     = hit_q;
  assign lk_way     = way_q;
  assign lk_onehot  = onehot_q;
  assign lk_multi   = multi_q;
  assign lk_data    = hit_q ? ram_q : '0;
  assign victim_way = ptr;
endmodule

// File: rtl/assoc_line_cache_chk.sv
// Port-level properties of the line store, bound to the top module.
module assoc_line_cache_chk #(
  parameter int ENTRIES = 64,
  parameter int WAY_W   = $clog2(ENTRIES)
) (
  input logic               clk,
  input logic               rst,
  input logic               lk_valid,
  input logic               fill_valid,
  input logic               lk_done,
  input logic               lk_hit,
  input logic [WAY_W-1:0]   lk_way,
  input logic [ENTRIES-1:0] lk_onehot,
  input logic               lk_multi,
  input logic [WAY_W-1:0]   victim_way
);
  // R2
  req_gives_done_chk: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> lk_done);

  // R2
  no_req_no_done_chk: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !lk_done);

  // R4
  hit_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    (lk_done && lk_hit) |-> ($countones(lk_onehot) == 1 && lk_onehot[lk_way]));

  // R4
  miss_clean_chk: assert property (@(posedge clk) disable iff (rst)
    (lk_done && !lk_hit) |-> (lk_onehot == '0 && lk_way == '0 && !lk_multi));

  // R7
  fill_moves_ptr_chk: assert property (@(posedge clk) disable iff (rst)
    fill_valid |=> (victim_way == WAY_W'((32'($past(victim_way)) + 1) % ENTRIES)));

  // R6
  idle_ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!fill_valid && !lk_valid) |=> $stable(victim_way));

  // R6
  miss_ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!fill_valid && lk_valid) |=> (!lk_hit -> $stable(victim_way)));

  // R5
  multi_needs_hit_chk: assert property (@(posedge clk) disable iff (rst)
    lk_multi |-> lk_hit);
endmodule

bind assoc_line_cache assoc_line_cache_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .lk_valid   (lk_valid),
  .fill_valid (fill_valid),
  .lk_done    (lk_done),
  .lk_hit     (lk_hit),
  .lk_way     (lk_way),
  .lk_onehot  (lk_onehot),
  .lk_multi   (lk_multi),
  .victim_way (victim_way)
);

// File: tb/assoc_line_cache_test.sv
`timescale 1ns/1ps
module assoc_line_cache_test;
  localparam int N   = 64;
  localparam int WW  = 6;
  localparam int LW  = 256;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          lk_valid = 1'b0;
  logic [31:0]   lk_addr = '0;
  logic          lk_done, lk_hit, lk_multi;
  logic [WW-1:0] lk_way, victim_way;
  logic [N-1:0]  lk_onehot;
  logic [LW-1:0] lk_data;
  logic          fill_valid = 1'b0;
  logic [31:0]   fill_addr = '0;
  logic [LW-1:0] fill_data = '0;

  always #10 clk = ~clk;  // 50 MHz

  assoc_line_cache uut (
    .clk(clk), .rst(rst),
    .lk_valid(lk_valid), .lk_addr(lk_addr),
    .lk_done(lk_done), .lk_hit(lk_hit), .lk_way(lk_way),
    .lk_onehot(lk_onehot), .lk_data(lk_data), .lk_multi(lk_multi),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data),
    .victim_way(victim_way)
  );

  typedef struct packed {
    logic          hit;
    logic [WW-1:0] way;
    logic          multi;
    logic [LW-1:0] data;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  bit   finished = 0;

  // Independent model of the slots and pointer
  bit            m_vld [N];
  logic [26:0]   m_tag [N];
  logic [LW-1:0] m_dat [N];
  int            m_ptr;

  function automatic logic [LW-1:0] mk_line(logic [26:0] t, logic [31:0] salt);
    return {8{{5'b0, t} ^ salt}};
  endfunction

  function automatic exp_t predict(logic [26:0] t);
    exp_t e;
    int   cnt = 0;
    e = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (m_vld[i] && m_tag[i] == t) begin
        e.hit = 1'b1; e.way = WW'(i); e.data = m_dat[i]; cnt++;
      end
    end
    e.multi = (cnt > 1);
    return e;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < N; i++) m_vld[i] = 0;
    m_ptr = 0;
  endtask

  // Driver: one lookup and/or fill in a single cycle
  task automatic op(bit do_lk, logic [26:0] lt, logic [4:0] lofs,
                    bit do_fill, logic [26:0] ft, logic [31:0] salt);
    exp_t e;
    lk_valid   = do_lk;
    lk_addr    = {lt, lofs};
    fill_valid = do_fill;
    fill_addr  = {ft, 5'h1f ^ lofs};
    fill_data  = mk_line(ft, salt);
    if (do_lk) begin
      e = predict(lt);
      exp_q.push_back(e);
    end
    if (do_fill) begin
      m_vld[m_ptr] = 1; m_tag[m_ptr] = ft; m_dat[m_ptr] = mk_line(ft, salt);
      m_ptr = (m_ptr + 1) % N;
    end else if (do_lk && e.hit && int'(e.way) == m_ptr) begin
      m_ptr = (m_ptr + 1) % N;
    end
    @(negedge clk);
    lk_valid = 1'b0; fill_valid = 1'b0;
  endtask

  task automatic lookup(logic [26:0] t, logic [4:0] ofs);
    op(1, t, ofs, 0, '0, '0);
  endtask

  task automatic fill(logic [26:0] t, logic [31:0] salt);
    op(0, '0, '0, 1, t, salt);
  endtask

  task automatic chk_ptr(string req);
    checks++;
    if (int'(victim_way) != m_ptr) begin
      errors++;
      $display("FAIL %s R10 victim_way actual=%0d expected=%0d", req, victim_way, m_ptr);
    end
  endtask

  // Monitor: compares each result against the queued expectation (R2, R4, R5)
  always @(negedge clk) begin
    if (!rst && lk_done) begin
      exp_t e;
      logic [N-1:0] oh;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R2 unexpected lk_done actual=1 expected=0");
      end else begin
        e  = exp_q.pop_front();
        oh = e.hit ? (N'(1) << e.way) : '0;
        if (lk_hit !== e.hit || lk_way !== e.way || lk_multi !== e.multi ||
            lk_onehot !== oh || lk_data !== e.data) begin
          errors++;
          $display("FAIL R4/R5 result actual hit=%0b way=%0d multi=%0b oh=%h data=%h expected hit=%0b way=%0d multi=%0b oh=%h data=%h",
                   lk_hit, lk_way, lk_multi, lk_onehot, lk_data,
                   e.hit, e.way, e.multi, oh, e.data);
        end
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [26:0] t1, t3, tx;
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    checks++;
    if (lk_done !== 1'b0) begin
      errors++; $display("FAIL R1 lk_done actual=%0b expected=0", lk_done);
    end
    chk_ptr("R1");
    lookup(27'h1000, 5'd0);           // R1: empty store misses

    // R7: fill advances pointer
    fill(27'd100, 32'hA5A5_0000);
    chk_ptr("R7");
    for (int i = 1; i < N; i++) fill(27'(100 + 7 * i), 32'hA5A5_0000 + i);
    chk_ptr("R8");                    // R8: wrapped back to 0

    // R3/R4/R6: each tag hits its slot regardless of byte offset;
    // sequential hits on the pointed slot walk the pointer round.
    for (int i = 0; i < N; i++) lookup(27'(100 + 7 * i), 5'(i));
    chk_ptr("R6 walk");
    lookup(27'(100 + 7 * 5), 5'h1f);  // R6: hit elsewhere, no move
    chk_ptr("R6 other");
    lookup(27'h7ff_0001, 5'd3);       // R6: miss, no move
    chk_ptr("R6 miss");
    lookup(27'd100, 5'd9);            // R6: hit on pointed slot 0 -> 1
    chk_ptr("R6 pointed");

    // R7: fill replaces slot 1
    t1 = 27'(100 + 7 * 1);
    fill(27'h555_5555, 32'h1234_5678);
    chk_ptr("R7 replace");
    lookup(t1, 5'd0);                 // R7: old tag gone
    lookup(27'h555_5555, 5'd4);       // R7: new tag hits slot 1

    // R5: duplicate of slot 10's tag lands in slot 2
    fill(27'(100 + 7 * 10), 32'hDEAD_BEEF);
    lookup(27'(100 + 7 * 10), 5'd2);  // R5: way 2, multi
    chk_ptr("R5");

    // R9: fill and lookup together on the pointed slot
    t3 = m_tag[m_ptr];
    tx = 27'h0ab_cdef;
    op(1, t3, 5'd7, 1, tx, 32'h0F0F_0F0F);
    chk_ptr("R9 single advance");
    lookup(t3, 5'd0);                 // R9: overwritten tag now misses
    lookup(tx, 5'd1);                 // R9: new tag hits

    // R8: drive pointer to 63 with fills, then one more wraps
    while (m_ptr != N - 1) fill(27'(9000 + m_ptr), 32'h0);
    chk_ptr("R8 at last");
    fill(27'd77777, 32'h3C3C_3C3C);
    chk_ptr("R8 wrap");
    lookup(27'd77777, 5'd0);          // R8: slot 63 holds it

    // R1: reset mid-run empties the store
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    exp_q.delete();
    chk_ptr("R1 rerun");
    lookup(27'd77777, 5'd0);
    lookup(27'd100, 5'd0);

    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R2 pending results actual=%0d expected=0", exp_q.size());
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule